// File: doc/BRIEF.md
# Planar Video Read Data Path

This block forms the byte handed back to the processor when it reads from a four-plane video memory. The memory delivers one byte from every plane for the addressed location. The block turns those plane bytes into a single result byte. One configuration bit picks between two ways of doing this.

In plane mode the result is the byte of the one plane named by a two-bit selector. In match mode every bit position is treated as one pixel. The pixel's colour is made up of one bit from each plane. The block compares that colour against a reference colour and sets the result bit when they are equal. A per-plane care mask decides which planes take part in the comparison.

The result is captured in a register on a read strobe. It stays unchanged until the next strobe, so the processor bus can sample it at leisure.

Top module: `vrd_read_path`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first strobe, `rd_data_o` is 8'h00.
- R2: When `read_mode_i` is 0, a strobe loads the plane byte chosen by `map_sel_i`. Plane p occupies `planes_i[8p+7:8p]`.
- R3: When `read_mode_i` is 1, a strobe loads a match byte. Bit i of that byte is 1 exactly when, for every plane p with `cmp_care_i[p]`=1, bit i of plane p equals `cmp_color_i[p]`.
- R4: A plane whose `cmp_care_i` bit is 0 has no influence on the match. When `cmp_care_i` is 4'b0000, the match byte is 8'hFF.
- R5: `rd_data_o` changes only on a rising clock edge at which `rd_stb_i` is 1. It is loaded at that edge and holds its value on all other edges, whatever the other inputs do.
- R6: In match mode `map_sel_i` has no effect. In plane mode `cmp_color_i` and `cmp_care_i` have no effect.
- R7: Match bit i depends only on bit i of each plane, with no bit reordering. Bit 7 is the leftmost pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Read strobe; loads the result register |
| read_mode_i | input | 1 | 0 = plane mode, 1 = match mode |
| map_sel_i | input | 2 | Plane chosen in plane mode |
| cmp_color_i | input | 4 | Reference colour, one bit per plane |
| cmp_care_i | input | 4 | Per-plane compare enable (1 = plane compared) |
| planes_i | input | 32 | Four plane bytes, plane p at bits 8p+7:8p |
| rd_data_o | output | 8 | Registered read byte |

## Verification
The bench selects each of the four planes with distinct byte values, which exposes a swapped or truncated selector. It checks match mode with the care mask fully set, partly set and fully cleared. A design that inverts the meaning of the care bits, or that returns zero instead of all ones when no plane is compared, fails these checks. Single-pixel patterns at bit 7 and bit 0 catch a design that mirrors pixel order. Hold checks with the strobe low, together with values fed to unused inputs, catch a register that loads freely or a mode that leaks the wrong field.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  typedef enum logic {
    RD_PLANE = 1'b0,
    RD_MATCH = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/vrd_plane_mux.sv
module vrd_plane_mux #(
  parameter int NUM_PLANES = 4,
  parameter int PIX_W      = 8,
  localparam int SEL_W     = $clog2(NUM_PLANES)
) (
  input  logic [NUM_PLANES*PIX_W-1:0] planes_i,
  input  logic [SEL_W-1:0]            sel_i,
  output logic [PIX_W-1:0]            byte_o
);
  logic [PIX_W-1:0] plane_arr [NUM_PLANES];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_unpack
    assign plane_arr[p] = planes_i[p*PIX_W +: PIX_W];
  end

  assign byte_o = plane_arr[sel_i];
endmodule

// File: rtl/vrd_color_match.sv
module vrd_color_match #(
  parameter int NUM_PLANES = 4,
  parameter int PIX_W      = 8
) (
  input  logic [NUM_PLANES*PIX_W-1:0] planes_i,
  input  logic [NUM_PLANES-1:0]       color_i,
  input  logic [NUM_PLANES-1:0]       care_i,
  output logic [PIX_W-1:0]            match_o
);
  for (genvar i = 0; i < PIX_W; i++) begin : g_pix
    logic [NUM_PLANES-1:0] pix;
    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_pl
      assign pix[p] = planes_i[p*PIX_W + i];
    end
    // excluded planes always count as a match
    assign match_o[i] = &(~(pix ^ color_i) | ~care_i);
  end
endmodule

// File: rtl/vrd_read_path.sv
module vrd_read_path
  import vrd_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PIX_W      = 8,
  localparam int SEL_W     = $clog2(NUM_PLANES),
  localparam int BUS_W     = NUM_PLANES * PIX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_stb_i,
  input  logic               read_mode_i,
  input  logic [SEL_W-1:0]   map_sel_i,
  input  logic [NUM_PLANES-1:0] cmp_color_i,
  input  logic [NUM_PLANES-1:0] cmp_care_i,
  input  logic [BUS_W-1:0]   planes_i,
  output logic [PIX_W-1:0]   rd_data_o
);
  rd_mode_e         mode;
  logic [PIX_W-1:0] plane_byte;
  logic [PIX_W-1:0] match_byte;
  logic [PIX_W-1:0] rd_next;

  assign mode = rd_mode_e'(read_mode_i);

  vrd_plane_mux #(.NUM_PLANES(NUM_PLANES), .PIX_W(PIX_W)) u_mux (
    .planes_i (planes_i),
    .sel_i    (map_sel_i),
    .byte_o   (plane_byte)
  );

  vrd_color_match #(.NUM_PLANES(NUM_PLANES), .PIX_W(PIX_W)) u_match (
    .planes_i (planes_i),
    .color_i  (cmp_color_i),
    .care_i   (cmp_care_i),
    .match_o  (match_byte)
  );

  always_comb begin
    unique case (mode)
      RD_MATCH: rd_next = match_byte;
      default:  rd_next = plane_byte;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= rd_next;
  end
endmodule

// File: rtl/vrd_read_path_chk.sv
module vrd_read_path_chk #(
  parameter int NUM_PLANES = 4,
  parameter int PIX_W      = 8,
  localparam int SEL_W     = $clog2(NUM_PLANES),
  localparam int BUS_W     = NUM_PLANES * PIX_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_stb_i,
  input logic                  read_mode_i,
  input logic [SEL_W-1:0]      map_sel_i,
  input logic [NUM_PLANES-1:0] cmp_color_i,
  input logic [NUM_PLANES-1:0] cmp_care_i,
  input logic [BUS_W-1:0]      planes_i,
  input logic [PIX_W-1:0]      rd_data_o
);
  // every compared plane is uniformly equal to its colour bit
  function automatic logic all_uniform(input logic [BUS_W-1:0] pl,
                                       input logic [NUM_PLANES-1:0] col,
                                       input logic [NUM_PLANES-1:0] care);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < NUM_PLANES; p++)
      if (care[p] && pl[p*PIX_W +: PIX_W] != {PIX_W{col[p]}}) ok = 1'b0;
    return ok;
  endfunction

  AST_HOLD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o)); // R5

  AST_PLANE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !read_mode_i) |=>
      rd_data_o == $past(planes_i[map_sel_i*PIX_W +: PIX_W])); // R2

  AST_NO_CARE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && read_mode_i && cmp_care_i == '0) |=> rd_data_o == '1); // R4

  AST_UNIFORM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && read_mode_i && all_uniform(planes_i, cmp_color_i, cmp_care_i))
      |=> rd_data_o == '1); // R3

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (rd_data_o == '0); // R1
  end
endmodule

bind vrd_read_path vrd_read_path_chk #(.NUM_PLANES(NUM_PLANES), .PIX_W(PIX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_stb_i    (rd_stb_i),
  .read_mode_i (read_mode_i),
  .map_sel_i   (map_sel_i),
  .cmp_color_i (cmp_color_i),
  .cmp_care_i  (cmp_care_i),
  .planes_i    (planes_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/vrd_read_path_tb.sv
module vrd_read_path_tb;
  typedef struct packed {
    logic        mode;
    logic [1:0]  sel;
    logic [3:0]  color;
    logic [3:0]  care;
    logic [31:0] planes;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 4'h0, 4'h0, 32'hA3B2C1D0, 8'hD0},  // R2
    '{1'b0, 2'd1, 4'h0, 4'h0, 32'hA3B2C1D0, 8'hC1},  // R2
    '{1'b0, 2'd2, 4'h0, 4'h0, 32'hA3B2C1D0, 8'hB2},  // R2
    '{1'b0, 2'd3, 4'h5, 4'hF, 32'hA3B2C1D0, 8'hA3},  // R2 R6 compare fields ignored
    '{1'b1, 2'd0, 4'hF, 4'hF, 32'hFFFFFFFF, 8'hFF},  // R3
    '{1'b1, 2'd0, 4'h0, 4'hF, 32'h00000000, 8'hFF},  // R3
    '{1'b1, 2'd0, 4'h5, 4'hF, 32'h00FF0FF0, 8'hF0},  // R3
    '{1'b1, 2'd3, 4'h5, 4'h4, 32'h00FF0FF0, 8'hFF},  // R4 R6 sel ignored
    '{1'b1, 2'd1, 4'h3, 4'h0, 32'h12345678, 8'hFF},  // R4 no plane compared
    '{1'b1, 2'd0, 4'h0, 4'h1, 32'h0000007F, 8'h80},  // R7 leftmost pixel
    '{1'b1, 2'd0, 4'h1, 4'h1, 32'h00000001, 8'h01},  // R7 rightmost pixel
    '{1'b1, 2'd0, 4'hA, 4'hA, 32'hC35581FF, 8'h81}   // R3 R4 mixed care
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_stb_i = 1'b0;
  logic        read_mode_i = 1'b0;
  logic [1:0]  map_sel_i = '0;
  logic [3:0]  cmp_color_i = '0;
  logic [3:0]  cmp_care_i = '0;
  logic [31:0] planes_i = '0;
  logic [7:0]  rd_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  vrd_read_path u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_stb_i    (rd_stb_i),
    .read_mode_i (read_mode_i),
    .map_sel_i   (map_sel_i),
    .cmp_color_i (cmp_color_i),
    .cmp_care_i  (cmp_care_i),
    .planes_i    (planes_i),
    .rd_data_o   (rd_data_o)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd_data_o !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, rd_data_o, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [1:0] s, input logic [3:0] c,
                       input logic [3:0] k, input logic [31:0] p, input logic stb);
    @(negedge clk_i);
    read_mode_i = m; map_sel_i = s; cmp_color_i = c; cmp_care_i = k;
    planes_i = p; rd_stb_i = stb;
    @(negedge clk_i);
    rd_stb_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 8'h00);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].mode, VECS[v].sel, VECS[v].color, VECS[v].care, VECS[v].planes, 1'b1);
      check($sformatf("R2/R3/R4/R6/R7 vector %0d", v), VECS[v].exp);
    end

    // R5: no strobe, changed inputs must not reach the output
    drive(1'b0, 2'd2, 4'h0, 4'h0, 32'h00110000, 1'b1);
    check("R5 load", 8'h11);
    drive(1'b0, 2'd0, 4'h0, 4'h0, 32'hDEADBEEF, 1'b0);
    check("R5 hold plane mode", 8'h11);
    drive(1'b1, 2'd0, 4'h0, 4'h0, 32'hDEADBEEF, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R5 hold match mode", 8'h11);

    // R6: plane mode with compare fields toggled gives the same byte
    drive(1'b0, 2'd1, 4'hF, 4'h0, 32'h44332211, 1'b1);
    check("R6 plane mode, care off", 8'h22);
    drive(1'b0, 2'd1, 4'h0, 4'hF, 32'h44332211, 1'b1);
    check("R6 plane mode, care on", 8'h22);

    // R1: asynchronous reset clears a loaded value
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule